// File: doc/BRIEF.md
# UART interrupt priority and identification

This block merges the interrupt sources of a UART into one interrupt request line and an identification byte that the CPU reads to find which source needs service. There are three tiers of source. Receiver line status is the highest. Received data sits in the middle, raised either when the receive FIFO holds enough characters or when the character timeout expires. Transmitter holding register empty is the lowest. Each tier has its own enable bit. A FIFO-enable bit selects between FIFO operation, where a programmable trigger level applies, and single-character operation.

The line-status, timeout and transmit-empty conditions come from the surrounding UART as level inputs. The receive FIFO fill level and the trigger level come in as numbers. The block compares the two numbers itself and also drives the data-ready status bit. A transmit-empty event is held in a pending flag. The flag clears when the CPU writes the holding register. It also clears when the CPU reads the identification byte while transmit-empty is the reported source. With FIFOs enabled and every enable bit at zero, the UART is in polled mode: software sees status only, and no request is raised.

Top module: `uart_irq_ident`

## Requirements
- R1: When `line_stat_cond` and `ie_line_stat` are both 1, `iir[3:0]` is 4'h6 and `irq` is 1, whatever the other sources are doing.
- R2: With `fifo_en`=1, received data available (code 4'h4) is reported while `rx_level` >= `rx_trigger`, and it drops in the same cycle that the level falls below the trigger. With `fifo_en`=0, it is reported while `rx_level` is nonzero. It needs `ie_rx_data`=1 and no line-status interrupt.
- R3: The character timeout (`timeout_cond`, code 4'hC) counts only with `fifo_en`=1, shares the received-data tier, and loses to code 4'h4 when both are present. It outranks transmit empty.
- R4: A rising edge on `tx_empty_cond` sets the transmit-empty pending flag on that clock edge. The flag is reported as code 4'h2 when `ie_tx_empty`=1 and no higher source is present. A `thr_wr` pulse, or `tx_empty_cond` going low, clears the flag at the next clock edge.
- R5: An `iir_rd` pulse in a cycle where `iir[3:0]` is 4'h2 clears the transmit-empty flag. An `iir_rd` pulse while another code is reported leaves the flag set.
- R6: With no enabled source present, `iir[3:0]` is 4'h1 and `irq` is 0. In particular, with `fifo_en`=1 and all three enables at 0 (polled mode), `irq` stays 0.
- R7: `iir[7:6]` is 2'b11 when `fifo_en`=1 and 2'b00 otherwise, and `iir[5:4]` is always 2'b00.
- R8: `data_ready` is 1 exactly when `rx_level` is nonzero.
- R9: During and straight after reset, the transmit-empty flag is clear, so with all conditions low `iir[3:0]` is 4'h1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| ie_rx_data | input | 1 | Enable for the received-data tier (data and timeout) |
| ie_tx_empty | input | 1 | Enable for transmit-holding-empty |
| ie_line_stat | input | 1 | Enable for receiver line status |
| line_stat_cond | input | 1 | Receiver line error condition present |
| timeout_cond | input | 1 | Character timeout expired |
| tx_empty_cond | input | 1 | Transmit holding register/FIFO empty |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Programmed trigger level |
| iir_rd | input | 1 | CPU read strobe of the identification byte |
| thr_wr | input | 1 | CPU write strobe of the transmit holding register |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Interrupt identification byte |
| data_ready | output | 1 | Receive data ready status |

## Verification
Random cycles draw every source, enable and strobe independently. Level and trigger are drawn across 0 to the full depth, so equality, one-below and one-above of the trigger all occur. These cycles separate correct tier ordering from wrong ordering and check that the FIFO bit gates the trigger comparison. Directed sequences walk the level across the trigger in both directions to show the same-cycle set and clear. They set the transmit-empty flag and then clear it once by write and once by an identification read. They also read the identification byte while line status is reported, to show the flag survives that read. Polled mode and the reset state are tried on their own.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      IRQ_NONE    = 4'h1,
      IRQ_TX_MT   = 4'h2,
      IRQ_RX_DATA = 4'h4,
      IRQ_LINE    = 4'h6,
      IRQ_TIMEOUT = 4'hC
   } irq_code_e;
endpackage

// File: rtl/uart_irq_rx_cond.sv
module uart_irq_rx_cond #(
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             timeout_cond,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trigger,
   output logic             trig_hit,
   output logic             tmo_hit,
   output logic             not_empty
);
   always_comb begin
      not_empty = (rx_level != '0);
      if (fifo_en) trig_hit = (rx_level >= rx_trigger);
      else         trig_hit = not_empty;
      tmo_hit = fifo_en & timeout_cond;
   end

   // R2
   trig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && rx_level < rx_trigger) |-> !trig_hit);
   // R3
   tmo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> !tmo_hit);
endmodule

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_empty_cond,
   input  logic thr_wr,
   input  logic iir_rd,
   input  logic tx_reported,
   output logic pend
);
   logic prev_empty;
   logic rise, clr;

   always_comb begin
      rise = tx_empty_cond & ~prev_empty;
      clr  = thr_wr | (iir_rd & tx_reported) | ~tx_empty_cond;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_empty <= 1'b0;
         pend       <= 1'b0;
      end else begin
         prev_empty <= tx_empty_cond;
         if (clr)       pend <= 1'b0;
         else if (rise) pend <= 1'b1;
      end
   end

   // R4
   thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !pend);
   // R5
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && tx_reported) |=> !pend);
   // R4
   set_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_empty_cond) && !thr_wr && !(iir_rd && tx_reported)) |=> pend);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ie_line_stat,
   input  logic      ie_rx_data,
   input  logic      ie_tx_empty,
   input  logic      line_stat_cond,
   input  logic      trig_hit,
   input  logic      tmo_hit,
   input  logic      tx_pend,
   output irq_code_e code,
   output logic      req
);
   always_comb begin
      if (ie_line_stat && line_stat_cond)  code = IRQ_LINE;
      else if (ie_rx_data && trig_hit)     code = IRQ_RX_DATA;
      else if (ie_rx_data && tmo_hit)      code = IRQ_TIMEOUT;
      else if (ie_tx_empty && tx_pend)     code = IRQ_TX_MT;
      else                                 code = IRQ_NONE;
      req = (code != IRQ_NONE);
   end

   // R1
   line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_line_stat && line_stat_cond) |-> (code == IRQ_LINE && req));
   // R6
   polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_line_stat && !ie_rx_data && !ie_tx_empty) |-> !req);
   // R3
   tmo_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == IRQ_TIMEOUT) |-> !trig_hit);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter bit OUT_REG    = 1'b0,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             ie_rx_data,
   input  logic             ie_tx_empty,
   input  logic             ie_line_stat,
   input  logic             line_stat_cond,
   input  logic             timeout_cond,
   input  logic             tx_empty_cond,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trigger,
   input  logic             iir_rd,
   input  logic             thr_wr,
   output logic             irq,
   output logic [7:0]       iir,
   output logic             data_ready
);
   localparam logic [1:0] FIFO_TAG = 2'b11;

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("uart_irq_ident: FIFO_DEPTH must be at least 2");
   end
   if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_width
      $error("uart_irq_ident: LVL_W too narrow for FIFO_DEPTH");
   end

   logic      trig_hit, tmo_hit, tx_pend, tx_reported;
   irq_code_e code;
   logic      req;
   logic [7:0] iir_next;

   uart_irq_rx_cond #(.LVL_W(LVL_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .timeout_cond(timeout_cond),
      .rx_level(rx_level), .rx_trigger(rx_trigger),
      .trig_hit(trig_hit), .tmo_hit(tmo_hit), .not_empty(data_ready)
   );

   uart_irq_thre_latch u_thre (
      .clk(clk), .rst_n(rst_n), .tx_empty_cond(tx_empty_cond), .thr_wr(thr_wr),
      .iir_rd(iir_rd), .tx_reported(tx_reported), .pend(tx_pend)
   );

   uart_irq_prio u_prio (
      .clk(clk), .rst_n(rst_n), .ie_line_stat(ie_line_stat), .ie_rx_data(ie_rx_data),
      .ie_tx_empty(ie_tx_empty), .line_stat_cond(line_stat_cond),
      .trig_hit(trig_hit), .tmo_hit(tmo_hit), .tx_pend(tx_pend),
      .code(code), .req(req)
   );

   always_comb iir_next = {(fifo_en ? FIFO_TAG : 2'b00), 2'b00, code};

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            iir <= {4'h0, IRQ_NONE};
            irq <= 1'b0;
         end else begin
            iir <= iir_next;
            irq <= req;
         end
      end
   end else begin : g_comb_out
      always_comb begin
         iir = iir_next;
         irq = req;
      end
   end

   always_comb tx_reported = (iir[3:0] == IRQ_TX_MT);

   // R7
   fifo_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir[5:4] == 2'b00) && (iir[0] == !irq));
   // R8
   ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready == (rx_level != '0));
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int LW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic fifo_en = 0, ie_rx = 0, ie_tx = 0, ie_ls = 0;
   logic ls = 0, tmo = 0, txe = 0, rd = 0, wr = 0;
   logic [LW-1:0] lvl = '0, trg = '0;
   logic irq, dr;
   logic [7:0] iir;

   int n_run = 0, n_fail = 0;
   logic m_pend = 0, m_prev = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_ident #(.FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ie_rx_data(ie_rx),
      .ie_tx_empty(ie_tx), .ie_line_stat(ie_ls), .line_stat_cond(ls),
      .timeout_cond(tmo), .tx_empty_cond(txe), .rx_level(lvl), .rx_trigger(trg),
      .iir_rd(rd), .thr_wr(wr), .irq(irq), .iir(iir), .data_ready(dr)
   );

   function automatic logic [3:0] exp_code();
      logic th;
      th = fifo_en ? (lvl >= trg) : (lvl != 0);
      if (ie_ls && ls)              return 4'h6;
      else if (ie_rx && th)         return 4'h4;
      else if (ie_rx && fifo_en && tmo) return 4'hC;
      else if (ie_tx && m_pend)     return 4'h2;
      else                          return 4'h1;
   endfunction

   function automatic logic [7:0] exp_iir();
      return {(fifo_en ? 2'b11 : 2'b00), 2'b00, exp_code()};
   endfunction

   function automatic string tag_of(logic [3:0] c);
      case (c)
         4'h6: return "R1";
         4'h4: return "R2";
         4'hC: return "R3";
         4'h2: return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compare all outputs against the model, then advance the model one edge
   task automatic step(string req);
      logic [7:0] e;
      logic nxt;
      #1;
      e = exp_iir();
      check(req, iir, e);
      check(req, {7'd0, irq}, {7'd0, e[3:0] != 4'h1});
      check("R8", {7'd0, dr}, {7'd0, lvl != 0});
      nxt = (wr || (rd && e[3:0] == 4'h2) || !txe) ? 1'b0 : ((txe && !m_prev) || m_pend);
      @(posedge clk);
      m_pend = nxt;
      m_prev = txe;
      @(negedge clk);
      rd = 0; wr = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9", iir, 8'h01);
      check("R9", {7'd0, irq}, 8'h00);
      rst_n = 1;
      @(negedge clk);
      step("R9");

      // R2 trigger crossing, FIFO mode
      fifo_en = 1; ie_rx = 1; trg = 8;
      lvl = 7; step("R2");
      lvl = 8; step("R2");
      lvl = 9; step("R2");
      lvl = 7; step("R2");
      // R2 non-FIFO: any character
      fifo_en = 0; lvl = 1; step("R2");
      // R3 timeout gated by fifo_en, loses to data
      tmo = 1; lvl = 0; step("R3");
      fifo_en = 1; step("R3");
      lvl = 8; step("R3");
      lvl = 0; tmo = 0;
      // R4 set by rising edge, cleared by write
      ie_tx = 1; txe = 1; step("R4");
      step("R4");
      wr = 1; step("R4");
      step("R4");
      // R5 read while line status shown keeps flag, read while 02h clears
      txe = 0; step("R5");
      txe = 1; step("R5");
      ie_ls = 1; ls = 1; rd = 1; step("R5");
      ls = 0; step("R5");
      check("R5", iir, 8'hC2);
      rd = 1; step("R5");
      step("R5");
      check("R5", iir, 8'hC1);
      // R1 line over everything
      ls = 1; tmo = 1; lvl = 16; trg = 1; step("R1");
      // R6 polled mode
      ie_ls = 0; ie_rx = 0; ie_tx = 0; step("R6");
      // R7 tag bits
      fifo_en = 0; step("R7");
      ls = 0; tmo = 0; lvl = 0;

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         fifo_en = r[0]; ie_rx = r[1]; ie_tx = r[2]; ie_ls = r[3];
         ls = (r[7:4] == 0); tmo = r[8] & r[9];
         txe = (r[12:10] != 0); rd = r[13] & r[14]; wr = (r[18:15] == 0);
         lvl = LW'($urandom_range(0, DEPTH));
         trg = LW'($urandom_range(1, DEPTH));
         #1;
         step(tag_of(exp_code()));
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule